// File: doc/BRIEF.md
# General-Purpose I/O Pin Bank with Masked Batch Configuration

This block is the register side of a 32-pin general-purpose I/O port, sitting on a plain memory-mapped bus with single-cycle writes. Direction and output state are each held in one 32-bit register. Software changes that state only through set and clear aliases, so no read-modify-write is needed. The pin inputs pass through a two-flop synchronizer into a readable input register. The input enable of each pin gates its bit.

Each pin has a configuration byte. Its implemented fields are peripheral-routing enable, input enable, pull enable and strong drive. The bytes can be written one lane at a time or a whole word at a time. Each pin also has a 4-bit routing selector.

A write-only batch register applies one configuration pattern and/or one selector value to any masked subset of sixteen pins in the lower or upper half of the port, in a single write. The pull enable and pull direction of every pin are brought out for a pad model. Pull direction follows the pin's output bit. A pin that reads low while pulled up means a closed switch to ground.

Top module: `gpio_pinbank`

## Requirements
- R1: After reset, the direction, output, configuration bytes and routing selectors are all zero, and so are every pad-facing output and every register read.
- R2: A write to offset 0x08 sets each direction bit whose data bit is 1, and a write to 0x04 clears each such bit. Data bits that are 0 leave their direction bits unchanged. A read of either offset returns the direction register.
- R3: A write to 0x18 sets output bits and a write to 0x14 clears output bits, with the same 1-acts, 0-ignores rule. A read of either offset returns the output register, and no other access changes it.
- R4: The configuration byte of pin n lives in the word at 0x40 + 4*(n/4), in byte lane n%4. A write changes only the lanes whose byte enable is 1. Only bits 0 (routing enable), 1 (input enable), 2 (pull enable) and 6 (strong drive) are stored; the other bits read as zero.
- R5: A full-word write at 0x44 updates pins 4 to 7 together, with pin 4 in bits 7:0 and pin 7 in bits 31:24.
- R6: A write to the batch register at 0x28 with bit 30 set and bit 31 clear loads the configuration byte of every pin i in 0 to 15 whose mask bit i (bits 15:0) is 1. The byte is built from data bit 16 (routing enable), bit 17 (input enable), bit 18 (pull enable) and bit 22 (strong drive). Pins whose mask bit is 0 keep their bytes.
- R7: With batch bit 31 set, mask bit i selects pin 16+i instead, and the lower half is untouched.
- R8: A batch write with bit 30 clear changes no configuration byte. With bit 28 set, it loads data bits 27:24 into the routing selector of each masked pin. A read of 0x28 returns zero.
- R9: A read of 0x20 returns each pin level two clock edges after it is applied, through two flops. A pin whose input enable is 0 reads 0.
- R10: The pull-enable output of each pin follows its pull-enable bit. Its pull direction follows its output bit, 1 for pull-up and 0 for pull-down. The strong-drive and routing-enable outputs follow their configuration bits.
- R11: Every write takes effect at the clock edge that samples it, so a read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_be | input | 4 | Byte lane enables, used by configuration writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pin_in | input | 32 | Pin levels from the pads |
| dir_o | output | 32 | Direction, 1 drives the pin |
| out_o | output | 32 | Output levels |
| pull_en_o | output | 32 | Pull resistor enable per pin |
| pull_up_o | output | 32 | Pull direction per pin, 1 up |
| drv_strong_o | output | 32 | Strong drive select per pin |
| pmux_en_o | output | 32 | Peripheral routing enable per pin |
| pmux_sel_o | output | 128 | Routing selector, 4 bits per pin, pin n in bits 4n+3:4n |

## Verification
The bench goes after the half-select of the batch register. A design that ignored bit 31 would rewrite pins 0 and 1 when pins 16 and 17 were meant. It checks that a batch write with the configuration enable clear, but with a full mask, leaves every byte as it was, and that the selector enable writes only the selector. Lane ordering within a configuration word is read back after both a single-lane write and a full-word write, which catches a reversed lane map or a write that ignores byte enables. The input path is sampled one and two cycles after a pin change, so a one-flop or three-flop path shows up, and pins with input disabled are driven high to show the gating.

// File: rtl/gpio_pinbank_pkg.sv
package gpio_pinbank_pkg;

    localparam int unsigned NPINS   = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned MUX_W   = 4;
    localparam int unsigned CFG_W   = 8;
    localparam int unsigned HALF_N  = 16;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IN      = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_BATCH   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h40;

    // configuration byte fields
    localparam int unsigned CB_ROUTE = 0;
    localparam int unsigned CB_INEN  = 1;
    localparam int unsigned CB_PULL  = 2;
    localparam int unsigned CB_DRV   = 6;
    localparam logic [CFG_W-1:0] CFG_KEEP = 8'h47;

    // batch word fields
    localparam int unsigned BT_ROUTE  = 16;
    localparam int unsigned BT_INEN   = 17;
    localparam int unsigned BT_PULL   = 18;
    localparam int unsigned BT_DRV    = 22;
    localparam int unsigned BT_MUX_LO = 24;
    localparam int unsigned BT_MUX_WE = 28;
    localparam int unsigned BT_CFG_WE = 30;
    localparam int unsigned BT_HIGH   = 31;

    typedef struct packed {
        logic [HALF_N-1:0] mask;
        logic              high;
        logic              cfg_we;
        logic              mux_we;
        logic [CFG_W-1:0]  cfg;
        logic [MUX_W-1:0]  mux;
    } batch_t;

    function automatic batch_t unpack_batch(input logic [DATA_W-1:0] w);
        batch_t b;
        b.mask   = w[HALF_N-1:0];
        b.high   = w[BT_HIGH];
        b.cfg_we = w[BT_CFG_WE];
        b.mux_we = w[BT_MUX_WE];
        b.cfg    = '0;
        b.cfg[CB_ROUTE] = w[BT_ROUTE];
        b.cfg[CB_INEN]  = w[BT_INEN];
        b.cfg[CB_PULL]  = w[BT_PULL];
        b.cfg[CB_DRV]   = w[BT_DRV];
        b.mux    = w[BT_MUX_LO +: MUX_W];
        return b;
    endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    assign set_bits = set_we ? wdata : '0;
    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_we || clr_we) begin
            q <= (q & ~clr_bits) | set_bits;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] enable,
    output logic [W-1:0] level
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= pins;
            stage2 <= stage1;
        end
    end

    assign level = stage2 & enable;
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_pinbank_pkg::*;
#(
    parameter int unsigned PINS = 32,
    localparam int unsigned WORDS  = PINS / 4,
    localparam int unsigned WIDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_we,
    input  logic [WIDX_W-1:0]       word_idx,
    input  logic [3:0]              be,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    batch_we,
    input  batch_t                  batch,
    output logic [PINS*CFG_W-1:0]   cfg_q,
    output logic [PINS*MUX_W-1:0]   mux_q
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int unsigned LANE = p % 4;
        localparam int unsigned WORD = p / 4;
        localparam int unsigned SLOT = p % HALF_N;
        localparam bit          UPPER = (p >= HALF_N);

        logic bus_hit;
        logic sel_hit;
        logic cfg_hit;
        logic mux_hit;

        assign bus_hit = word_we && (word_idx == WIDX_W'(WORD)) && be[LANE];
        assign sel_hit = batch_we && (batch.high == UPPER) && batch.mask[SLOT];
        assign cfg_hit = sel_hit && batch.cfg_we;
        assign mux_hit = sel_hit && batch.mux_we;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[p*CFG_W +: CFG_W] <= '0;
            end else if (bus_hit) begin
                cfg_q[p*CFG_W +: CFG_W] <= wdata[LANE*CFG_W +: CFG_W] & CFG_KEEP;
            end else if (cfg_hit) begin
                cfg_q[p*CFG_W +: CFG_W] <= batch.cfg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mux_q[p*MUX_W +: MUX_W] <= '0;
            end else if (mux_hit) begin
                mux_q[p*MUX_W +: MUX_W] <= batch.mux;
            end
        end
    end
endmodule

// File: rtl/gpio_pinbank.sv
module gpio_pinbank
    import gpio_pinbank_pkg::*;
#(
    parameter int unsigned PINS = NPINS,
    localparam int unsigned WIDX_W = $clog2(PINS / 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [PINS-1:0]       pin_in,
    output logic [PINS-1:0]       dir_o,
    output logic [PINS-1:0]       out_o,
    output logic [PINS-1:0]       pull_en_o,
    output logic [PINS-1:0]       pull_up_o,
    output logic [PINS-1:0]       drv_strong_o,
    output logic [PINS-1:0]       pmux_en_o,
    output logic [PINS*MUX_W-1:0] pmux_sel_o
);
    logic                   wr_cyc;
    logic                   rd_cyc;
    logic                   cfg_region;
    logic [WIDX_W-1:0]      cfg_idx;
    logic [PINS*CFG_W-1:0]  cfg_q;
    logic [PINS-1:0]        in_enable;
    logic [PINS-1:0]        in_level;
    batch_t                 batch;

    assign wr_cyc     = bus_sel && bus_wr;
    assign rd_cyc     = bus_sel && !bus_wr;
    assign cfg_region = ({1'b0, bus_addr} >= {1'b0, OFS_CFG})
                     && ({1'b0, bus_addr} <  ({1'b0, OFS_CFG} + 9'(PINS)));
    assign cfg_idx    = bus_addr[WIDX_W+1:2];
    assign batch      = unpack_batch(bus_wdata);

    gpio_setclr_reg #(.W(PINS)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_cyc && bus_addr == OFS_DIR_SET),
        .clr_we (wr_cyc && bus_addr == OFS_DIR_CLR),
        .wdata  (bus_wdata[PINS-1:0]),
        .q      (dir_o)
    );

    gpio_setclr_reg #(.W(PINS)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_cyc && bus_addr == OFS_OUT_SET),
        .clr_we (wr_cyc && bus_addr == OFS_OUT_CLR),
        .wdata  (bus_wdata[PINS-1:0]),
        .q      (out_o)
    );

    gpio_cfg_bank #(.PINS(PINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_we  (wr_cyc && cfg_region),
        .word_idx (cfg_idx),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .batch_we (wr_cyc && bus_addr == OFS_BATCH),
        .batch    (batch),
        .cfg_q    (cfg_q),
        .mux_q    (pmux_sel_o)
    );

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (pin_in),
        .enable (in_enable),
        .level  (in_level)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pad
        assign in_enable[p]    = cfg_q[p*CFG_W + CB_INEN];
        assign pull_en_o[p]    = cfg_q[p*CFG_W + CB_PULL];
        assign drv_strong_o[p] = cfg_q[p*CFG_W + CB_DRV];
        assign pmux_en_o[p]    = cfg_q[p*CFG_W + CB_ROUTE];
        assign pull_up_o[p]    = out_o[p];
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            case (bus_addr)
                OFS_DIR_CLR, OFS_DIR_SET: bus_rdata = DATA_W'(dir_o);
                OFS_OUT_CLR, OFS_OUT_SET: bus_rdata = DATA_W'(out_o);
                OFS_IN:                   bus_rdata = DATA_W'(in_level);
                default: begin
                    if (cfg_region) begin
                        bus_rdata = cfg_q[int'(cfg_idx)*DATA_W +: DATA_W];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_pinbank_chk.sv
module gpio_pinbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] dir_o,
    input logic [31:0] out_o,
    input logic [31:0] pull_en_o,
    input logic [31:0] drv_strong_o
);
    logic wr_cyc;
    assign wr_cyc = bus_sel && bus_wr;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (dir_o == '0 && out_o == '0 && pull_en_o == '0 && drv_strong_o == '0));

    assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == 8'h08) |=> ((dir_o & $past(bus_wdata)) == $past(bus_wdata)));

    assert_dir_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == 8'h04) |=> ((dir_o & $past(bus_wdata)) == '0));

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cyc && (bus_addr == 8'h14 || bus_addr == 8'h18)) |=> $stable(out_o));

    assert_batch_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 8'h28) |-> (bus_rdata == '0));

    assert_batch_nocfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == 8'h28 && !bus_wdata[30]) |=> ($stable(pull_en_o) && $stable(drv_strong_o)));
endmodule

bind gpio_pinbank gpio_pinbank_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .dir_o        (dir_o),
    .out_o        (out_o),
    .pull_en_o    (pull_en_o),
    .drv_strong_o (drv_strong_o)
);

// File: tb/gpio_pinbank_tb_top.sv
module gpio_pinbank_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [3:0]   bus_be = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  pin_in = '0;
    logic [31:0]  dir_o, out_o, pull_en_o, pull_up_o, drv_strong_o, pmux_en_o;
    logic [127:0] pmux_sel_o;

    always #5 clk = ~clk;

    gpio_pinbank dut_i (
        .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_be (bus_be), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .pin_in (pin_in), .dir_o (dir_o), .out_o (out_o),
        .pull_en_o (pull_en_o), .pull_up_o (pull_up_o), .drv_strong_o (drv_strong_o),
        .pmux_en_o (pmux_en_o), .pmux_sel_o (pmux_sel_o)
    );

    // kinds: 0 read data, 1 dir, 2 out, 3 pull_en, 4 pull_up, 5 drive,
    //        6 selector pin 8, 7 selector pin 0, 8 routing enable
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  mon_req = 1'b0;
    int    total = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always @(negedge clk) begin
        if (mon_req && q.size() != 0) begin
            item_t       it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = dir_o;
                2: act = out_o;
                3: act = pull_en_o;
                4: act = pull_up_o;
                5: act = drv_strong_o;
                6: act = {28'd0, pmux_sel_o[35:32]};
                7: act = {28'd0, pmux_sel_o[3:0]};
                default: act = pmux_en_o;
            endcase
            total++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; mon_req = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
        q.push_back('{0, e, t});
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic chk(input int k, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        q.push_back('{k, e, t});
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; pin_in = v;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, 32'h0, "R1 dir");
        rd(8'h14, 32'h0, "R1 out");
        rd(8'h44, 32'h0, "R1 cfg");
        chk(3, 32'h0, "R1 pull_en");
        chk(7, 32'h0, "R1 selector");

        // R2 direction aliases; R11 read right after write
        wr(8'h08, 32'h0000_F00F, 4'hF);
        rd(8'h08, 32'h0000_F00F, "R11 dir after set");
        wr(8'h08, 32'h00F0_0000, 4'hF);
        wr(8'h04, 32'h0000_0003, 4'hF);
        rd(8'h04, 32'h00F0_F00C, "R2 dir set/clr");
        chk(1, 32'h00F0_F00C, "R2 dir_o");

        // R3 output aliases, zero data ignored
        wr(8'h18, 32'h0000_0080, 4'hF);
        wr(8'h14, 32'h0, 4'hF);
        wr(8'h18, 32'h0, 4'hF);
        rd(8'h14, 32'h0000_0080, "R3 out");

        // R4 single lane write, reserved bits dropped
        wr(8'h44, 32'hFF00_0000, 4'b1000);
        rd(8'h44, 32'h4700_0000, "R4 pin7 lane");
        rd(8'h40, 32'h0, "R4 other word");

        // R5 full word write, pin 7 top byte
        wr(8'h44, 32'h0102_4406, 4'hF);
        rd(8'h44, 32'h0102_4406, "R5 word");

        // R6 batch lower half, pins 0 and 7, input+pull
        wr(8'h28, 32'h4006_0081, 4'hF);
        rd(8'h44, 32'h0602_4406, "R6 pins4-7");
        rd(8'h40, 32'h0000_0006, "R6 pin0");

        // R7 batch upper half, pins 16,17 routing+strong
        wr(8'h28, 32'hC041_0003, 4'hF);
        rd(8'h50, 32'h0000_4141, "R7 pins16-17");
        rd(8'h40, 32'h0000_0006, "R7 lower untouched");
        chk(5, 32'h0003_0020, "R7 drv_strong_o");
        chk(8, 32'h0003_0000, "R7 pmux_en_o");

        // R8 no cfg write enable, selector write, readback zero
        wr(8'h28, 32'h0004_FFFF, 4'hF);
        rd(8'h40, 32'h0000_0006, "R8 cfg kept lower");
        rd(8'h50, 32'h0000_4141, "R8 cfg kept upper");
        wr(8'h28, 32'h1A00_0100, 4'hF);
        chk(6, 32'h0000_000A, "R8 selector pin8");
        chk(7, 32'h0, "R8 selector pin0");
        rd(8'h48, 32'h0, "R8 pin8 cfg kept");
        rd(8'h28, 32'h0, "R8 batch reads zero");

        // R9 two-flop input path with enable gating
        drive_pins(32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R9 one edge");
        rd(8'h20, 32'h0000_00D1, "R9 two edges");

        // R10 pull outputs, switch closed on pin 7
        chk(3, 32'h0000_00B1, "R10 pull_en_o");
        chk(4, 32'h0000_0080, "R10 pull_up_o");
        drive_pins(32'hFFFF_FF7F);
        rd(8'h20, 32'h0000_00D1, "R9 one edge low");
        rd(8'h20, 32'h0000_0051, "R10 closed switch");
        wr(8'h14, 32'h0000_0080, 4'hF);
        chk(4, 32'h0, "R10 pull down");

        idle();
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule